// File: doc/BRIEF.md
# Hart Debug Halt/Resume Controller

This block sits beside a hart's privilege and status logic and moves the hart into and out of the halted debug state. A one-cycle entry strobe carries the current program counter, a halt cause code, and the hart's privilege level and virtualization state. On that edge the block raises its halted flag and captures a resume address and a debug control/status word. A one-cycle resume strobe reads that saved word back. It picks a privilege and virtualization mode that the configured hart can actually run in, presents the resume address, and pulses clear requests for the memory-privilege, double-trap and landing-pad state that the surrounding status registers hold.

The set of extensions present on the hart comes from static configuration inputs: hypervisor, supervisor, user, compressed instructions, landing pads, and the two double-trap levels. A master enable turns the whole feature off. While the hart is halted, trigger hits that arrive are not passed on. Every update is registered and happens on the clock edge that samples the strobe, so all results are visible one cycle after the strobe.

Top module: `dbg_mode_ctl`

## Requirements
- R1: While `cfg_dbg_en` is 0, entry and resume strobes change nothing: `dbg_mode`, `dpc`, `dcsr` hold and no `res_valid`/`elp_wr` pulse appears.
- R2: Entry sets `dbg_mode` and loads `dpc` with `enter_pc` with bit 0 cleared, and with bit 1 also cleared when `cfg_rvc` is 0.
- R3: Entry writes `dcsr[1:0]` with `cur_priv` (U=0, S=1, M=3) and `dcsr[8:6]` with `enter_cause[2:0]`, leaving the higher cause bits unused.
- R4: Entry sets `dcsr[5]` only when `cur_virt` and `cfg_has_h` are both 1, and clears it otherwise.
- R5: With `cfg_lp` set, entry copies `cur_elp` into `dcsr[18]` and pulses `elp_wr` with `elp_wdata`=0. With `cfg_lp` clear, `dcsr[18]` is untouched and no `elp_wr` pulse appears.
- R6: Resume takes its privilege from `dcsr[1:0]`, and the reserved value 2 resolves to M. Virtualization comes from `dcsr[5]` only when `cfg_has_h` is 1, and it is always 0 when the target is M.
- R7: A saved S target without `cfg_has_s` resumes to M. A saved U target without `cfg_has_u` resumes to S if `cfg_has_s`, else to M. Both cases resume with virtualization 0.
- R8: With `cfg_lp` set, resume pulses `elp_wr` with `elp_wdata` = `fcfi_en` AND `dcsr[18]`, and clears `dcsr[18]`.
- R9: One cycle after an accepted resume strobe, `res_valid` pulses for one cycle with `res_pc` equal to `dpc`, and `dbg_mode` is 0.
- R10: A resume to a privilege other than M pulses `clr_mprv`. It also pulses `clr_mdt` if `cfg_mdt` is 1.
- R11: With `cfg_sdt` set, a resume to U or to a virtualized mode pulses `clr_sdt`. A resume to virtualized U also pulses `clr_vs_sdt`.
- R12: `trig_fire` follows `trig_hit` one cycle later, but only when `dbg_mode` was 0 in the cycle of the hit.
- R13: An entry strobe while halted and a resume strobe while not halted are ignored.
- R14: After reset `dbg_mode`=0, `dpc`=0, `dcsr`=0x3, and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbg_en | input | 1 | Master enable for halt/resume |
| cfg_has_h | input | 1 | Hypervisor extension present |
| cfg_has_s | input | 1 | Supervisor mode present |
| cfg_has_u | input | 1 | User mode present |
| cfg_rvc | input | 1 | Compressed instructions enabled |
| cfg_lp | input | 1 | Landing-pad support present |
| cfg_mdt | input | 1 | Machine double-trap support present |
| cfg_sdt | input | 1 | Supervisor double-trap support present |
| enter_req | input | 1 | Halt strobe |
| enter_pc | input | XLEN | Current program counter |
| enter_cause | input | CAUSE_IN_W | Halt cause, low 3 bits kept |
| cur_priv | input | 2 | Current privilege |
| cur_virt | input | 1 | Current virtualization state |
| cur_elp | input | 1 | Current expected-landing-pad bit |
| resume_req | input | 1 | Resume strobe |
| fcfi_en | input | 1 | Forward control-flow integrity enabled for target |
| trig_hit | input | 1 | Raw trigger match |
| dbg_mode | output | 1 | Halted flag |
| dpc | output | XLEN | Saved resume address |
| dcsr | output | DCSR_W | Debug control/status word |
| res_valid | output | 1 | Resume result pulse |
| res_pc | output | XLEN | Address to resume at |
| res_priv | output | 2 | Legal resume privilege |
| res_virt | output | 1 | Resume virtualization state |
| clr_mprv | output | 1 | Clear memory-privilege modify bit |
| clr_mdt | output | 1 | Clear machine double-trap bit |
| clr_sdt | output | 1 | Clear supervisor double-trap bit |
| clr_vs_sdt | output | 1 | Clear virtual-supervisor double-trap bit |
| elp_wr | output | 1 | Write strobe for expected-landing-pad bit |
| elp_wdata | output | 1 | Value for expected-landing-pad bit |
| trig_fire | output | 1 | Gated trigger hit |

## Verification
The bench builds the block with its defaults: a 32-bit address, a 32-bit control word and a 4-bit cause input. The fourth cause bit lets the bench show that only three cause bits are stored. The address width is enough to show both alignment masks on one pattern. The configuration inputs are changed between halt and resume, so every legalization branch is reached: missing supervisor, missing user, missing hypervisor, reserved privilege, and double-trap support turned off.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam int PRV_LO   = 0;
  localparam int PRV_W    = 2;
  localparam int VIRT_BIT = 5;
  localparam int CAUSE_LO = 6;
  localparam int CAUSE_W  = 3;
  localparam int PELP_BIT = 18;

  typedef struct packed {
    logic has_h;
    logic has_s;
    logic has_u;
    logic rvc;
    logic lp;
    logic mdt;
    logic sdt;
  } hart_cfg_t;

endpackage

// File: rtl/dbg_entry_calc.sv
module dbg_entry_calc
  import dbg_mode_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int DCSR_W     = 32,
  parameter int CAUSE_IN_W = 4
) (
  input  hart_cfg_t             cfg,
  input  logic [XLEN-1:0]       pc_in,
  input  logic [CAUSE_IN_W-1:0] cause_in,
  input  logic [1:0]            priv_in,
  input  logic                  virt_in,
  input  logic                  elp_in,
  input  logic [DCSR_W-1:0]     dcsr_cur,
  output logic [XLEN-1:0]       dpc_nxt,
  output logic [DCSR_W-1:0]     dcsr_nxt
);

  // Resume address: instruction alignment depends on compressed support
  always_comb begin
    dpc_nxt    = pc_in;
    dpc_nxt[0] = 1'b0;
    if (!cfg.rvc) dpc_nxt[1] = 1'b0;
  end

  // Control word: replace cause, privilege and virt fields, keep the rest
  always_comb begin
    dcsr_nxt                        = dcsr_cur;
    dcsr_nxt[PRV_LO +: PRV_W]       = priv_in;
    dcsr_nxt[VIRT_BIT]              = virt_in & cfg.has_h;
    dcsr_nxt[CAUSE_LO +: CAUSE_W]   = cause_in[CAUSE_W-1:0];
    if (cfg.lp) dcsr_nxt[PELP_BIT]  = elp_in;
  end

endmodule

// File: rtl/dbg_resume_calc.sv
module dbg_resume_calc
  import dbg_mode_pkg::*;
#(
  parameter int DCSR_W = 32
) (
  input  hart_cfg_t         cfg,
  input  logic [DCSR_W-1:0] dcsr_cur,
  input  logic              fcfi_en,
  output priv_e             tgt_priv,
  output logic              tgt_virt,
  output logic              clr_mprv,
  output logic              clr_mdt,
  output logic              clr_sdt,
  output logic              clr_vs_sdt,
  output logic              elp_val,
  output logic [DCSR_W-1:0] dcsr_nxt
);

  logic [PRV_W-1:0] saved_priv;
  logic             saved_virt;

  assign saved_priv = dcsr_cur[PRV_LO +: PRV_W];
  assign saved_virt = dcsr_cur[VIRT_BIT] & cfg.has_h;

  // Legalize the saved mode against the modes this hart implements
  always_comb begin
    tgt_priv = PRIV_M;
    tgt_virt = 1'b0;
    unique case (saved_priv)
      PRIV_U: begin
        if (cfg.has_u) begin
          tgt_priv = PRIV_U;
          tgt_virt = saved_virt;
        end else if (cfg.has_s) begin
          tgt_priv = PRIV_S;
        end
      end
      PRIV_S: begin
        if (cfg.has_s) begin
          tgt_priv = PRIV_S;
          tgt_virt = saved_virt;
        end
      end
      default: begin
        tgt_priv = PRIV_M;
        tgt_virt = 1'b0;
      end
    endcase
  end

  // Status clear requests derived from the legal target
  always_comb begin
    clr_mprv   = (tgt_priv != PRIV_M);
    clr_mdt    = cfg.mdt && (tgt_priv != PRIV_M);
    clr_sdt    = cfg.sdt && ((tgt_priv == PRIV_U) || tgt_virt);
    clr_vs_sdt = cfg.sdt && tgt_virt && (tgt_priv == PRIV_U);
  end

  // Landing-pad restore and clearing of the saved copy
  always_comb begin
    elp_val  = fcfi_en & dcsr_cur[PELP_BIT];
    dcsr_nxt = dcsr_cur;
    if (cfg.lp) dcsr_nxt[PELP_BIT] = 1'b0;
  end

endmodule

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl
  import dbg_mode_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int DCSR_W     = 32,
  parameter int CAUSE_IN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_dbg_en,
  input  logic                  cfg_has_h,
  input  logic                  cfg_has_s,
  input  logic                  cfg_has_u,
  input  logic                  cfg_rvc,
  input  logic                  cfg_lp,
  input  logic                  cfg_mdt,
  input  logic                  cfg_sdt,
  input  logic                  enter_req,
  input  logic [XLEN-1:0]       enter_pc,
  input  logic [CAUSE_IN_W-1:0] enter_cause,
  input  logic [1:0]            cur_priv,
  input  logic                  cur_virt,
  input  logic                  cur_elp,
  input  logic                  resume_req,
  input  logic                  fcfi_en,
  input  logic                  trig_hit,
  output logic                  dbg_mode,
  output logic [XLEN-1:0]       dpc,
  output logic [DCSR_W-1:0]     dcsr,
  output logic                  res_valid,
  output logic [XLEN-1:0]       res_pc,
  output logic [1:0]            res_priv,
  output logic                  res_virt,
  output logic                  clr_mprv,
  output logic                  clr_mdt,
  output logic                  clr_sdt,
  output logic                  clr_vs_sdt,
  output logic                  elp_wr,
  output logic                  elp_wdata,
  output logic                  trig_fire
);

  localparam logic [DCSR_W-1:0] DCSR_RST = DCSR_W'(PRIV_M);

  hart_cfg_t         cfg;
  logic [XLEN-1:0]   ent_dpc;
  logic [DCSR_W-1:0] ent_dcsr;
  logic [DCSR_W-1:0] res_dcsr;
  priv_e             rc_priv;
  logic              rc_virt, rc_mprv, rc_mdt, rc_sdt, rc_vs_sdt, rc_elp;
  logic              take_enter, take_resume;

  always_comb begin
    cfg.has_h = cfg_has_h;
    cfg.has_s = cfg_has_s;
    cfg.has_u = cfg_has_u;
    cfg.rvc   = cfg_rvc;
    cfg.lp    = cfg_lp;
    cfg.mdt   = cfg_mdt;
    cfg.sdt   = cfg_sdt;
  end

  dbg_entry_calc #(
    .XLEN(XLEN), .DCSR_W(DCSR_W), .CAUSE_IN_W(CAUSE_IN_W)
  ) u_entry (
    .cfg(cfg), .pc_in(enter_pc), .cause_in(enter_cause),
    .priv_in(cur_priv), .virt_in(cur_virt), .elp_in(cur_elp),
    .dcsr_cur(dcsr), .dpc_nxt(ent_dpc), .dcsr_nxt(ent_dcsr)
  );

  dbg_resume_calc #(.DCSR_W(DCSR_W)) u_resume (
    .cfg(cfg), .dcsr_cur(dcsr), .fcfi_en(fcfi_en),
    .tgt_priv(rc_priv), .tgt_virt(rc_virt), .clr_mprv(rc_mprv),
    .clr_mdt(rc_mdt), .clr_sdt(rc_sdt), .clr_vs_sdt(rc_vs_sdt),
    .elp_val(rc_elp), .dcsr_nxt(res_dcsr)
  );

  // Resume is only meaningful while halted, entry only while running
  assign take_resume = cfg_dbg_en &&  dbg_mode && resume_req;
  assign take_enter  = cfg_dbg_en && !dbg_mode && enter_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_mode   <= 1'b0;
      dpc        <= '0;
      dcsr       <= DCSR_RST;
      res_valid  <= 1'b0;
      res_pc     <= '0;
      res_priv   <= 2'd0;
      res_virt   <= 1'b0;
      clr_mprv   <= 1'b0;
      clr_mdt    <= 1'b0;
      clr_sdt    <= 1'b0;
      clr_vs_sdt <= 1'b0;
      elp_wr     <= 1'b0;
      elp_wdata  <= 1'b0;
      trig_fire  <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      clr_mprv   <= 1'b0;
      clr_mdt    <= 1'b0;
      clr_sdt    <= 1'b0;
      clr_vs_sdt <= 1'b0;
      elp_wr     <= 1'b0;
      elp_wdata  <= 1'b0;
      trig_fire  <= trig_hit && !dbg_mode;
      if (take_resume) begin
        dbg_mode   <= 1'b0;
        dcsr       <= res_dcsr;
        res_valid  <= 1'b1;
        res_pc     <= dpc;
        res_priv   <= rc_priv;
        res_virt   <= rc_virt;
        clr_mprv   <= rc_mprv;
        clr_mdt    <= rc_mdt;
        clr_sdt    <= rc_sdt;
        clr_vs_sdt <= rc_vs_sdt;
        elp_wr     <= cfg_lp;
        elp_wdata  <= cfg_lp && rc_elp;
      end else if (take_enter) begin
        dbg_mode <= 1'b1;
        dpc      <= ent_dpc;
        dcsr     <= ent_dcsr;
        elp_wr   <= cfg_lp;
      end
    end
  end

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_dbg_en |=> $stable(dbg_mode) && !res_valid && !elp_wr); // R1
  AST_DPC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |-> !dpc[0]); // R2
  AST_M_NO_VIRT: assert property (@(posedge clk) disable iff (rst)
    res_valid && (res_priv == PRIV_M) |-> !res_virt); // R6
  AST_NO_RSV_PRIV: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_priv != PRIV_RSV); // R6
  AST_S_LEGAL: assert property (@(posedge clk) disable iff (rst)
    res_valid && (res_priv == PRIV_S) |-> $past(cfg_has_s)); // R7
  AST_U_LEGAL: assert property (@(posedge clk) disable iff (rst)
    res_valid && (res_priv == PRIV_U) |-> $past(cfg_has_u)); // R7
  AST_RES_LEAVES: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !dbg_mode && $past(dbg_mode)); // R9
  AST_MPRV_WITH_RES: assert property (@(posedge clk) disable iff (rst)
    clr_mprv |-> res_valid && (res_priv != PRIV_M)); // R10
  AST_VS_SDT_SUB: assert property (@(posedge clk) disable iff (rst)
    clr_vs_sdt |-> clr_sdt && res_virt && (res_priv == PRIV_U)); // R11
  AST_TRIG_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(dbg_mode) |-> !trig_fire); // R12
  AST_HALT_HOLDS_DPC: assert property (@(posedge clk) disable iff (rst)
    dbg_mode && $past(dbg_mode) |-> $stable(dpc)); // R13

endmodule

// File: tb/test_dbg_mode_ctl.sv
module test_dbg_mode_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dbg_en, cfg_has_h, cfg_has_s, cfg_has_u, cfg_rvc;
  logic        cfg_lp, cfg_mdt, cfg_sdt;
  logic        enter_req = 1'b0;
  logic [31:0] enter_pc = '0;
  logic [3:0]  enter_cause = '0;
  logic [1:0]  cur_priv = '0;
  logic        cur_virt = 1'b0, cur_elp = 1'b0;
  logic        resume_req = 1'b0, fcfi_en = 1'b0, trig_hit = 1'b0;
  logic        dbg_mode;
  logic [31:0] dpc, dcsr, res_pc;
  logic        res_valid, res_virt, clr_mprv, clr_mdt, clr_sdt, clr_vs_sdt;
  logic [1:0]  res_priv;
  logic        elp_wr, elp_wdata, trig_fire;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_mode_ctl i_dbg_mode_ctl (
    .clk(clk), .rst(rst), .cfg_dbg_en(cfg_dbg_en), .cfg_has_h(cfg_has_h),
    .cfg_has_s(cfg_has_s), .cfg_has_u(cfg_has_u), .cfg_rvc(cfg_rvc),
    .cfg_lp(cfg_lp), .cfg_mdt(cfg_mdt), .cfg_sdt(cfg_sdt),
    .enter_req(enter_req), .enter_pc(enter_pc), .enter_cause(enter_cause),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .cur_elp(cur_elp),
    .resume_req(resume_req), .fcfi_en(fcfi_en), .trig_hit(trig_hit),
    .dbg_mode(dbg_mode), .dpc(dpc), .dcsr(dcsr), .res_valid(res_valid),
    .res_pc(res_pc), .res_priv(res_priv), .res_virt(res_virt),
    .clr_mprv(clr_mprv), .clr_mdt(clr_mdt), .clr_sdt(clr_sdt),
    .clr_vs_sdt(clr_vs_sdt), .elp_wr(elp_wr), .elp_wdata(elp_wdata),
    .trig_fire(trig_fire)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic full_cfg();
    cfg_dbg_en = 1; cfg_has_h = 1; cfg_has_s = 1; cfg_has_u = 1;
    cfg_rvc = 1; cfg_lp = 1; cfg_mdt = 1; cfg_sdt = 1;
  endtask

  task automatic enter(logic [31:0] pc, logic [3:0] cause, logic [1:0] p,
                       logic v, logic e);
    @(negedge clk);
    enter_pc = pc; enter_cause = cause; cur_priv = p; cur_virt = v;
    cur_elp = e; enter_req = 1;
    @(negedge clk);
    enter_req = 0;
  endtask

  task automatic resume(logic f);
    @(negedge clk);
    fcfi_en = f; resume_req = 1;
    @(negedge clk);
    resume_req = 0;
  endtask

  task automatic t_reset();
    chk("R14 dbg_mode", 32'(dbg_mode), 0);
    chk("R14 dpc", dpc, 0);
    chk("R14 dcsr", dcsr, 32'h3);
    chk("R14 pulses", {res_valid, clr_mprv, clr_mdt, clr_sdt, clr_vs_sdt, elp_wr, trig_fire}, 0);
  endtask

  task automatic t_disabled();
    full_cfg(); cfg_dbg_en = 0;
    enter(32'h0000_1234, 4'h1, 2'd0, 0, 1);
    chk("R1 entry ignored mode", 32'(dbg_mode), 0);
    chk("R1 entry ignored dpc", dpc, 0);
    chk("R1 entry ignored elp_wr", 32'(elp_wr), 0);
    cfg_dbg_en = 1;
    enter(32'h0000_2000, 4'h2, 2'd3, 0, 0);
    cfg_dbg_en = 0;
    resume(0);
    chk("R1 resume ignored mode", 32'(dbg_mode), 1);
    chk("R1 resume ignored valid", 32'(res_valid), 0);
    cfg_dbg_en = 1;
    resume(0);
    chk("R9 resume after reenable", 32'(res_valid), 1);
  endtask

  task automatic t_entry_fields();
    full_cfg();
    enter(32'h8000_1237, 4'hB, 2'd1, 1, 1);
    chk("R2 mode set", 32'(dbg_mode), 1);
    chk("R2 dpc rvc", dpc, 32'h8000_1236);
    chk("R3 cause", 32'(dcsr[8:6]), 3);
    chk("R3 prv", 32'(dcsr[1:0]), 1);
    chk("R4 v set", 32'(dcsr[5]), 1);
    chk("R5 pelp saved", 32'(dcsr[18]), 1);
    chk("R5 elp cleared", {30'd0, elp_wr, elp_wdata}, 32'b10);
    enter(32'h0000_4440, 4'h5, 2'd0, 0, 0);
    chk("R13 reentry dpc", dpc, 32'h8000_1236);
    chk("R13 reentry cause", 32'(dcsr[8:6]), 3);
    resume(1);
    chk("R8 elp restored", {30'd0, elp_wr, elp_wdata}, 32'b11);
    chk("R8 pelp cleared", 32'(dcsr[18]), 0);
    chk("R9 res_pc", res_pc, 32'h8000_1236);
    resume(0);
    chk("R13 resume when running", 32'(res_valid), 0);
    full_cfg(); cfg_rvc = 0; cfg_has_h = 0;
    enter(32'h0000_00FF, 4'h4, 2'd3, 1, 1);
    chk("R2 dpc no rvc", dpc, 32'h0000_00FC);
    chk("R4 v needs hyp", 32'(dcsr[5]), 0);
    chk("R3 cause 4", 32'(dcsr[8:6]), 4);
    resume(0);
    chk("R8 fcfi off", {30'd0, elp_wr, elp_wdata}, 32'b10);
    full_cfg(); cfg_lp = 0;
    enter(32'h0000_0100, 4'h1, 2'd3, 0, 1);
    chk("R5 lp off pelp", 32'(dcsr[18]), 0);
    chk("R5 lp off no elp_wr", 32'(elp_wr), 0);
    resume(1);
    chk("R8 lp off no elp_wr", 32'(elp_wr), 0);
  endtask

  task automatic resume_case(string tag, logic [1:0] p, logic v,
                             logic s, logic u, logic h, logic m, logic d,
                             logic [1:0] ep, logic ev, logic emprv,
                             logic emdt, logic esdt, logic evs);
    full_cfg();
    enter(32'h1000_0042, 4'h1, p, v, 0);
    cfg_has_s = s; cfg_has_u = u; cfg_has_h = h; cfg_mdt = m; cfg_sdt = d;
    resume(0);
    chk({tag, " R9 valid"}, 32'(res_valid), 1);
    chk({tag, " R9 pc"}, res_pc, 32'h1000_0042);
    chk({tag, " R9 mode"}, 32'(dbg_mode), 0);
    chk({tag, " priv"}, 32'(res_priv), 32'(ep));
    chk({tag, " virt"}, 32'(res_virt), 32'(ev));
    chk({tag, " R10 clears"}, {30'd0, clr_mprv, clr_mdt}, {30'd0, emprv, emdt});
    chk({tag, " R11 clears"}, {30'd0, clr_sdt, clr_vs_sdt}, {30'd0, esdt, evs});
    @(negedge clk);
    chk({tag, " R9 one pulse"}, 32'(res_valid), 0);
  endtask

  task automatic t_resume_table();
    resume_case("R6 VS",          2'd1, 1, 1, 1, 1, 1, 1, 2'd1, 1, 1, 1, 1, 0);
    resume_case("R11 VU",         2'd0, 1, 1, 1, 1, 1, 1, 2'd0, 1, 1, 1, 1, 1);
    resume_case("R6 M drops v",   2'd3, 1, 1, 1, 1, 1, 1, 2'd3, 0, 0, 0, 0, 0);
    resume_case("R6 reserved",    2'd2, 0, 1, 1, 1, 1, 1, 2'd3, 0, 0, 0, 0, 0);
    resume_case("R7 S absent",    2'd1, 1, 0, 1, 1, 1, 1, 2'd3, 0, 0, 0, 0, 0);
    resume_case("R7 U to S",      2'd0, 1, 1, 0, 1, 1, 1, 2'd1, 0, 1, 1, 0, 0);
    resume_case("R7 U to M",      2'd0, 0, 0, 0, 1, 1, 1, 2'd3, 0, 0, 0, 0, 0);
    resume_case("R6 hyp gone",    2'd1, 1, 1, 1, 0, 1, 1, 2'd1, 0, 1, 1, 0, 0);
    resume_case("R10 R11 off",    2'd0, 0, 1, 1, 1, 0, 0, 2'd0, 0, 1, 0, 0, 0);
    resume_case("R11 plain U",    2'd0, 0, 1, 1, 1, 1, 1, 2'd0, 0, 1, 1, 1, 0);
  endtask

  task automatic t_triggers();
    full_cfg();
    @(negedge clk); trig_hit = 1;
    @(negedge clk); trig_hit = 0;
    chk("R12 fire when running", 32'(trig_fire), 1);
    enter(32'h0000_0200, 4'h2, 2'd3, 0, 0);
    trig_hit = 1;
    @(negedge clk); trig_hit = 0;
    chk("R12 gated when halted", 32'(trig_fire), 0);
    resume(0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    full_cfg();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_entry_fields();
    t_resume_table();
    t_triggers();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule